// File: doc/BRIEF.md
# Four-Mode Self-Test Observer Register

This block is an n-bit register whose flip-flops serve four purposes, picked by a two-bit mode input. In its functional role it captures a parallel word from surrounding logic like any pipeline register. For test, the same flip-flops can form a serial shift chain, run on their own as a maximal-length pseudo-random pattern source, or fold a stream of parallel response words into a compact signature. Feedback taps for pattern generation and signature compaction come from a compile-time parameter, which should hold a primitive polynomial for the chosen width.

A typical arrangement places one such register in front of a logic block and another behind it. The front register generates stimulus while the rear one compacts the responses. Each register is seeded or read out through the scan path, and the two roles can be exchanged to test the logic on the opposite side. The register is cleared to zero either by the synchronous reset or by shifting zeros in through scan. Because an all-zero state cannot leave generator mode, a non-zero seed must be scanned in before patterns are generated.

The mode input is decoded into four named states: `MODE_SCAN` (00), `MODE_GEN` (01), `MODE_FUNC` (10) and `MODE_SIG` (11). Any state can move to any other on the next clock simply by changing the mode bits. Reset overrides every state.

Top module: `obs_register`

## Requirements
- R1: When `rst` is high at a rising clock edge, every stage becomes 0 regardless of `mode`.
- R2: With `mode` = 00 (scan), stage 0 takes `scan_in` and each stage i>0 takes stage i-1, so the bit shifted in first reaches the top stage after WIDTH clocks.
- R3: With `mode` = 01 (generate), stage 0 takes the XOR of all stages whose bit is set in `TAPS`, stage i>0 takes stage i-1, and `din` and `scan_in` have no effect.
- R4: With `mode` = 10 (functional), the register loads `din` in one clock.
- R5: With `mode` = 11 (signature), the next value is the generate-mode next value XORed bitwise with `din`.
- R6: `scan_out` always equals the top stage `q[WIDTH-1]` in every mode.
- R7: Shifting WIDTH zeros in scan mode clears the register from any prior content.
- R8: In generate mode with a primitive `TAPS` and a non-zero seed, the register passes through all 2^WIDTH-1 non-zero values and returns to the seed after exactly that many clocks.
- R9: In generate mode, an all-zero register stays all-zero, and a non-zero register never becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | Behaviour select: 00 scan, 01 generate, 10 functional, 11 signature |
| din | input | WIDTH | Parallel data from the logic under test |
| scan_in | input | 1 | Serial input into stage 0 |
| q | output | WIDTH | Parallel register contents |
| scan_out | output | 1 | Serial output, top stage |

## Verification
The bench builds two copies. The main copy uses WIDTH=8 with TAPS=8'hB8 and goes through every mode, mode switches, reset in mid-operation, the zero lockup case, and scan clearing against a bench model. A second copy with WIDTH=4 and TAPS=4'hC has a cycle of only 15 states, which is short enough to walk in full. On that copy the bench checks that every non-zero state is visited exactly once and that the register returns to its seed.

// File: rtl/obs_pkg.sv
package obs_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_FUNC = 2'b10,
        MODE_SIG  = 2'b11
    } mode_e;

    localparam int unsigned NUM_MODES = 4;

endpackage

// File: rtl/obs_mode_decode.sv
module obs_mode_decode
    import obs_pkg::*;
(
    input  logic [1:0]           mode_bits,
    output mode_e                mode_state,
    output logic [NUM_MODES-1:0] mode_onehot
);

    always_comb begin
        mode_state = mode_e'(mode_bits);
    end

    always_comb begin
        mode_onehot = '0;
        unique case (mode_state)
            MODE_SCAN: mode_onehot[0] = 1'b1;
            MODE_GEN:  mode_onehot[1] = 1'b1;
            MODE_FUNC: mode_onehot[2] = 1'b1;
            MODE_SIG:  mode_onehot[3] = 1'b1;
        endcase
    end

    always_comb begin
        assert_decode_onehot_R2: assert ($onehot(mode_onehot) || $isunknown(mode_bits));
    end

endmodule

// File: rtl/obs_feedback.sv
module obs_feedback #(
    parameter int unsigned        WIDTH = 8,
    parameter logic [WIDTH-1:0]   TAPS  = 8'hB8
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb_bit
);

    logic [WIDTH-1:0] tapped;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_tap
            if (TAPS[g]) begin : g_on
                assign tapped[g] = state[g];
            end else begin : g_off
                assign tapped[g] = 1'b0;
            end
        end
    endgenerate

    assign fb_bit = ^tapped;

endmodule

// File: rtl/obs_next_state.sv
module obs_next_state
    import obs_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  mode_e            mode_state,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  logic             scan_in,
    input  logic             fb_bit,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH-1:0] shifted_scan;
    logic [WIDTH-1:0] shifted_fb;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign shifted_scan[g] = scan_in;
                assign shifted_fb[g]   = fb_bit;
            end else begin : g_body
                assign shifted_scan[g] = cur[g-1];
                assign shifted_fb[g]   = cur[g-1];
            end
        end
    endgenerate

    always_comb begin
        unique case (mode_state)
            MODE_SCAN: nxt = shifted_scan;
            MODE_GEN:  nxt = shifted_fb;
            MODE_FUNC: nxt = din;
            MODE_SIG:  nxt = shifted_fb ^ din;
        endcase
    end

endmodule

// File: rtl/obs_register.sv
module obs_register
    import obs_pkg::*;
#(
    parameter int unsigned      WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] din,
    input  logic             scan_in,
    output logic [WIDTH-1:0] q,
    output logic             scan_out
);

    localparam int unsigned TOP = WIDTH - 1;

    mode_e                mode_state;
    logic [NUM_MODES-1:0] mode_onehot;
    logic                 fb_bit;
    logic [WIDTH-1:0]     state_q;
    logic [WIDTH-1:0]     state_d;

    obs_mode_decode u_decode (
        .mode_bits   (mode),
        .mode_state  (mode_state),
        .mode_onehot (mode_onehot)
    );

    obs_feedback #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) u_feedback (
        .state  (state_q),
        .fb_bit (fb_bit)
    );

    obs_next_state #(
        .WIDTH (WIDTH)
    ) u_next (
        .mode_state (mode_state),
        .cur        (state_q),
        .din        (din),
        .scan_in    (scan_in),
        .fb_bit     (fb_bit),
        .nxt        (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        q        = state_q;
        scan_out = state_q[TOP];
    end

    // Assertions
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_scan_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_onehot[0]) |=> (q[0] == $past(scan_in)) && (q[TOP:1] == $past(q[TOP-1:0])));

    assert_func_load_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_onehot[2]) |=> (q == $past(din)));

    assert_gen_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_onehot[1]) |=> (q[TOP:1] == $past(q[TOP-1:0])));

    assert_gen_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_onehot[1] && q != '0) |=> (q != '0));

    assert_gen_lockup_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_onehot[1] && q == '0) |=> (q == '0));

endmodule

// File: tb/obs_register_tb.sv
module obs_register_tb;

    localparam int unsigned W   = 8;
    localparam logic [W-1:0] TP = 8'hB8;
    localparam int unsigned W4  = 4;
    localparam logic [W4-1:0] TP4 = 4'hC;

    typedef struct {
        logic [W-1:0] exp_q;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] din = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] q;
    logic         scan_out;

    logic [1:0]    mode4 = 2'b00;
    logic          si4 = 1'b0;
    logic [W4-1:0] q4;
    logic          so4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] model = '0;
    item_t sb[$];

    always #4 clk = ~clk;

    obs_register #(.WIDTH(W), .TAPS(TP)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .din(din), .scan_in(scan_in),
        .q(q), .scan_out(scan_out)
    );

    obs_register #(.WIDTH(W4), .TAPS(TP4)) u_dut4 (
        .clk(clk), .rst(rst), .mode(mode4), .din('0), .scan_in(si4),
        .q(q4), .scan_out(so4)
    );

    function automatic logic [W-1:0] ref_next(input logic [1:0] m, input logic [W-1:0] s,
                                              input logic [W-1:0] dv, input logic sv);
        logic fb;
        logic [W-1:0] rot;
        fb  = ^(s & TP);
        rot = {s[W-2:0], fb};
        case (m)
            2'b00:   return {s[W-2:0], sv};
            2'b01:   return rot;
            2'b10:   return dv;
            default: return rot ^ dv;
        endcase
    endfunction

    task automatic drive(input logic [1:0] m, input logic [W-1:0] dv, input logic sv,
                         input logic r, input string tag);
        item_t it;
        @(negedge clk);
        mode    = m;
        din     = dv;
        scan_in = sv;
        rst     = r;
        model   = r ? '0 : ref_next(m, model, dv, sv);
        it.exp_q = model;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (q !== it.exp_q) begin
                    fails++;
                    $display("FAIL %s: q=%h expected %h", it.tag, q, it.exp_q);
                end
                checks++;
                if (scan_out !== it.exp_q[W-1]) begin
                    fails++;
                    $display("FAIL R6: scan_out=%b expected %b", scan_out, it.exp_q[W-1]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run incomplete expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] seed;
        logic [W4-1:0] seen_first;
        bit visited [16];
        bit dup;
        int cnt;
        seed = 8'hA5;

        // R1: reset state
        drive(2'b10, 8'hFF, 1'b1, 1'b1, "R1");
        drive(2'b01, 8'h3C, 1'b1, 1'b1, "R1");

        // R2: scan in a seed, first bit ends at top stage
        for (int i = W - 1; i >= 0; i--) drive(2'b00, 8'h5A, seed[i], 1'b0, "R2");

        // R3: generate mode, din and scan_in varied
        for (int i = 0; i < 20; i++) drive(2'b01, 8'(i * 37 + 11), 1'(i), 1'b0, "R3");

        // R4: functional load
        drive(2'b10, 8'h00, 1'b0, 1'b0, "R4");
        drive(2'b10, 8'hFF, 1'b1, 1'b0, "R4");
        drive(2'b10, 8'h81, 1'b0, 1'b0, "R4");
        drive(2'b10, 8'h7E, 1'b1, 1'b0, "R4");

        // R5: signature compaction
        for (int i = 0; i < 20; i++) drive(2'b11, 8'(i * 73 + 5), 1'b0, 1'b0, "R5");

        // R1: reset in mid-compaction
        drive(2'b11, 8'hC3, 1'b0, 1'b1, "R1");
        drive(2'b11, 8'h99, 1'b0, 1'b0, "R5");

        // R7: load ones, then shift zeros in
        drive(2'b10, 8'hFF, 1'b0, 1'b0, "R4");
        for (int i = 0; i < W; i++) drive(2'b00, 8'hAA, 1'b0, 1'b0, "R7");

        // R9: zero lockup in generate mode
        for (int i = 0; i < 6; i++) drive(2'b01, 8'hF0, 1'b1, 1'b0, "R9");

        // R8: full period on the 4-bit copy, seed 0001
        @(negedge clk);
        rst   = 1'b0;
        mode4 = 2'b00;
        for (int i = W4 - 1; i >= 0; i--) begin
            si4 = (i == 0);
            @(negedge clk);
        end
        mode4 = 2'b01;
        seen_first = q4;
        checks++;
        if (q4 !== 4'h1) begin
            fails++;
            $display("FAIL R8: seed=%h expected %h", q4, 4'h1);
        end
        foreach (visited[k]) visited[k] = 1'b0;
        dup = 1'b0;
        cnt = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (visited[q4]) dup = 1'b1;
            visited[q4] = 1'b1;
        end
        for (int k = 1; k < 16; k++) if (visited[k]) cnt++;
        checks++;
        if (dup || cnt != 15 || visited[0]) begin
            fails++;
            $display("FAIL R8: distinct nonzero states=%0d expected 15", cnt);
        end
        checks++;
        if (q4 !== seen_first) begin
            fails++;
            $display("FAIL R8: after 15 clocks q=%h expected %h", q4, seen_first);
        end

        @(negedge clk);
        @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2: scoreboard left=%0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule